// File: doc/BRIEF.md
# Quad-Lane Bundle Execute Stage

This block is the execute stage of a wide in-order integer core. Each clock it accepts a bundle of four consecutive 32-bit instructions, together with the address of the first one. It works out all four results in that same clock, using four combinational lanes that read a 32-entry by 32-bit register file. When an earlier lane in the bundle writes a register, a later lane that reads that register receives the new value at once, through a chain of bypass paths between lanes. No stall is needed and there is no pipeline register in between. Up to four register writes are committed together on the next rising clock edge.

The lanes cover a subset of the base 32-bit integer instructions: add and subtract, the logical operations, the set-less-than comparisons, and the two upper-immediate forms. Shifts and any other encoding pass through as no-ops. Loads and stores are not executed here. They may only be handed off from lane 0, so a load or store found in any other lane cuts the bundle short just before that lane. The stage reports how many lanes retired, and the fetch logic uses that count to advance its address. While the memory side reports an outstanding access, nothing retires.

Top module: `q4x_exec`

## Requirements
- R1: Register-form instructions (opcode bits 6:0 = 0110011) compute ADD (funct3 000, funct7 0000000), SUB (funct3 000, funct7 0100000), XOR (100), OR (110) and AND (111) on 32-bit operands, wrapping modulo 2^32.
- R2: Immediate-form instructions (opcode 0010011) compute ADDI, XORI, ORI and ANDI. The 12-bit immediate in bits 31:20 is sign-extended first.
- R3: SLT/SLTI (funct3 010) compare as signed and SLTU/SLTIU (funct3 011) compare as unsigned. SLTIU compares against the sign-extended immediate. The result is 1 or 0.
- R4: LUI (opcode 0110111) writes bits 31:12 followed by twelve zeros. AUIPC (opcode 0010111) adds that value to the lane's address, which is the bundle address plus 4 times the lane index.
- R5: A lane that reads a register written by a lower-numbered lane of the same bundle uses that lane's result in the same clock.
- R6: When several lanes of a bundle write one register, the highest-numbered writer is both the value seen by later readers and the value held after the clock edge.
- R7: Writes to x0 are dropped, and their lane's write enable stays low. Reads of x0 return zero, even when a lower lane in the bundle targeted x0.
- R8: Shifts (funct3 001 or 101), register forms with any other funct7, and unknown opcodes write nothing. They still count as retired.
- R9: With no load (opcode 0000011) or store (opcode 0100011) in the bundle, the retire count is 4. A load or store in lane k>0 gives a count of k. One in lane 0 gives a count of 1 with no register write. Lanes at or beyond the count never write.
- R10: While the memory-wait input is high, the retire count is 0 and no register is written.
- R11: While the bundle-valid input is low, the retire count is 0 and no register is written.
- R12: After reset, every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bndl_vld_i | input | 1 | Bundle present this cycle |
| mem_wait_i | input | 1 | A handed-off load or store is still outstanding |
| bndl_pc_i | input | 32 | Address of the lane 0 instruction |
| bndl_ins_i | input | 128 | Four instructions; lane k occupies bits 32k+31:32k |
| retire_o | output | 3 | Number of lanes retired this cycle (0 to 4) |
| wb_en_o | output | 4 | Per-lane register write enable |
| wb_rd_o | output | 20 | Per-lane destination register; lane k in bits 5k+4:5k |
| wb_data_o | output | 128 | Per-lane result; lane k in bits 32k+31:32k |

## Verification
In one cycle, the same-bundle bypass and the collision rule for several writers to one register can both be active. The bench provokes this with bundles in which two lanes write one register and later lanes read it. It also sends chains of increments that run through all four lanes, and bundles where a load or store cuts off the tail while the earlier lanes still forward. A shadow register file executes the retired lanes one at a time in lane order. The bench compares every enable, destination and result against that file. Later bundles then read the contested registers back, which confirms the committed value.

// File: rtl/q4x_pkg.sv
package q4x_pkg;

  localparam int XLEN  = 32;
  localparam int ILEN  = 32;
  localparam int NREG  = 32;
  localparam int RADDR = $clog2(NREG);

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;

  typedef enum logic [3:0] {
    ALU_NOP, ALU_ADD, ALU_SUB, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_OR, ALU_AND, ALU_LUI, ALU_AUIPC
  } alu_op_e;

  typedef struct packed {
    alu_op_e           op;
    logic              use_imm;
    logic [XLEN-1:0]   imm;
    logic [RADDR-1:0]  rd;
    logic [RADDR-1:0]  rs1;
    logic [RADDR-1:0]  rs2;
    logic              wr;
    logic              is_mem;
  } dec_t;

  // funct3 selection shared by register and immediate forms
  function automatic alu_op_e q4x_f3_op(input logic [2:0] f3);
    case (f3)
      3'b000:  return ALU_ADD;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b110:  return ALU_OR;
      3'b111:  return ALU_AND;
      default: return ALU_NOP;
    endcase
  endfunction

  function automatic dec_t q4x_decode(input logic [ILEN-1:0] ins);
    dec_t       d;
    logic [2:0] f3;
    logic [6:0] f7;
    d     = '0;
    f3    = ins[14:12];
    f7    = ins[31:25];
    d.op  = ALU_NOP;
    d.rd  = ins[11:7];
    d.rs1 = ins[19:15];
    d.rs2 = ins[24:20];
    case (ins[6:0])
      OPC_REG: begin
        if (f7 == 7'h00)                     d.op = q4x_f3_op(f3);
        else if (f7 == 7'h20 && f3 == 3'b000) d.op = ALU_SUB;
      end
      OPC_IMM: begin
        d.op      = q4x_f3_op(f3);
        d.use_imm = 1'b1;
        d.imm     = {{(XLEN-12){ins[31]}}, ins[31:20]};
      end
      OPC_LUI: begin
        d.op      = ALU_LUI;
        d.use_imm = 1'b1;
        d.imm     = {ins[31:12], 12'h000};
      end
      OPC_AUIPC: begin
        d.op      = ALU_AUIPC;
        d.use_imm = 1'b1;
        d.imm     = {ins[31:12], 12'h000};
      end
      OPC_LOAD, OPC_STORE: d.is_mem = 1'b1;
      default: ;
    endcase
    d.wr = (d.op != ALU_NOP);
    return d;
  endfunction

  function automatic logic [XLEN-1:0] q4x_alu(input dec_t d, input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b, input logic [XLEN-1:0] pc);
    logic [XLEN-1:0] y;
    y = d.use_imm ? d.imm : b;
    case (d.op)
      ALU_ADD:   return a + y;
      ALU_SUB:   return a - y;
      ALU_SLT:   return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(y))};
      ALU_SLTU:  return {{(XLEN-1){1'b0}}, (a < y)};
      ALU_XOR:   return a ^ y;
      ALU_OR:    return a | y;
      ALU_AND:   return a & y;
      ALU_LUI:   return d.imm;
      ALU_AUIPC: return pc + d.imm;
      default:   return '0;
    endcase
  endfunction

endpackage

// File: rtl/q4x_regfile.sv
module q4x_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int NRD  = 8,
  parameter int NWR  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_addr_i [NRD],
  output logic [XLEN-1:0] rd_data_o [NRD],
  input  logic            wr_en_i   [NWR],
  input  logic [AW-1:0]   wr_addr_i [NWR],
  input  logic [XLEN-1:0] wr_data_i [NWR]
);

  logic [XLEN-1:0] regs [NREG];

  // ports are visited in ascending order, so the highest port wins a collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int p = 0; p < NWR; p++)
        if (wr_en_i[p] && wr_addr_i[p] != '0) regs[wr_addr_i[p]] <= wr_data_i[p];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = (rd_addr_i[p] == '0) ? '0 : regs[rd_addr_i[p]];

    // R7
    x0_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_i[p] == '0) |-> (rd_data_o[p] == '0));
  end

endmodule

// File: rtl/q4x_retire.sv
module q4x_retire #(
  parameter int LANES = 4,
  localparam int CNTW = $clog2(LANES + 1)
) (
  input  logic             vld_i,
  input  logic             wait_i,
  input  logic [LANES-1:0] is_mem_i,
  output logic [CNTW-1:0]  cnt_o,
  output logic             mem_cut_o
);

  // the first memory lane ends the bundle; lane 0 itself is handed off and retires alone
  always_comb begin
    cnt_o     = CNTW'(LANES);
    mem_cut_o = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (!mem_cut_o && is_mem_i[k]) begin
        mem_cut_o = 1'b1;
        cnt_o     = (k == 0) ? CNTW'(1) : CNTW'(k);
      end
    end
    if (!vld_i || wait_i) cnt_o = '0;
  end

endmodule

// File: rtl/q4x_exec.sv
module q4x_exec
  import q4x_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CNTW = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bndl_vld_i,
  input  logic                  mem_wait_i,
  input  logic [XLEN-1:0]       bndl_pc_i,
  input  logic [LANES*ILEN-1:0] bndl_ins_i,
  output logic [CNTW-1:0]       retire_o,
  output logic [LANES-1:0]      wb_en_o,
  output logic [LANES*RADDR-1:0] wb_rd_o,
  output logic [LANES*XLEN-1:0] wb_data_o
);

  dec_t             dec_w  [LANES];
  logic [RADDR-1:0] ra_addr[2*LANES];
  logic [XLEN-1:0]  ra_data[2*LANES];
  logic [XLEN-1:0]  opa_w  [LANES];
  logic [XLEN-1:0]  opb_w  [LANES];
  logic [XLEN-1:0]  res_w  [LANES];
  logic             we_w   [LANES];
  logic [RADDR-1:0] wa_w   [LANES];
  logic [LANES-1:0] is_mem_w;
  logic [CNTW-1:0]  retire_w;
  logic             mem_cut_w;

  for (genvar k = 0; k < LANES; k++) begin : g_dec
    assign dec_w[k]       = q4x_decode(bndl_ins_i[k*ILEN +: ILEN]);
    assign ra_addr[2*k]   = dec_w[k].rs1;
    assign ra_addr[2*k+1] = dec_w[k].rs2;
    assign is_mem_w[k]    = dec_w[k].is_mem;
  end

  q4x_regfile #(
    .XLEN(XLEN), .NREG(NREG), .NRD(2*LANES), .NWR(LANES)
  ) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_i(ra_addr), .rd_data_o(ra_data),
    .wr_en_i(we_w), .wr_addr_i(wa_w), .wr_data_i(res_w)
  );

  q4x_retire #(.LANES(LANES)) u_ret (
    .vld_i(bndl_vld_i), .wait_i(mem_wait_i), .is_mem_i(is_mem_w),
    .cnt_o(retire_w), .mem_cut_o(mem_cut_w)
  );

  // bypass chain: scan lower lanes in order so the highest matching writer wins
  always_comb begin
    logic [XLEN-1:0] res_l [LANES];
    logic [XLEN-1:0] a, b;
    for (int k = 0; k < LANES; k++) begin
      a = ra_data[2*k];
      b = ra_data[2*k+1];
      for (int j = 0; j < k; j++) begin
        if (dec_w[j].wr && dec_w[j].rd != '0) begin
          if (dec_w[j].rd == dec_w[k].rs1) a = res_l[j];
          if (dec_w[j].rd == dec_w[k].rs2) b = res_l[j];
        end
      end
      opa_w[k] = a;
      opb_w[k] = b;
      res_l[k] = q4x_alu(dec_w[k], a, b, bndl_pc_i + XLEN'(4*k));
      res_w[k] = res_l[k];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_wb
    assign we_w[k] = dec_w[k].wr && (dec_w[k].rd != '0) && (CNTW'(k) < retire_w);
    assign wa_w[k] = dec_w[k].rd;
    assign wb_en_o[k]                 = we_w[k];
    assign wb_rd_o[k*RADDR +: RADDR]  = dec_w[k].rd;
    assign wb_data_o[k*XLEN +: XLEN]  = res_w[k];

    // R9
    beyond_retire_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o[k] |-> (CNTW'(k) < retire_o));
  end

  assign retire_o = retire_w;

  // R9
  retire_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_o <= CNTW'(LANES)) && (!mem_cut_w || !bndl_vld_i || mem_wait_i || retire_o != CNTW'(LANES)));

  // R10
  mem_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wait_i |-> (wb_en_o == '0 && retire_o == '0));

  // R11
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bndl_vld_i |-> (wb_en_o == '0 && retire_o == '0));

  if (LANES > 1) begin : g_byp_chk
    // R5
    lane1_fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_w[0].wr && dec_w[0].rd != '0 && dec_w[0].rd == dec_w[1].rs1) |-> (opa_w[1] == res_w[0]));
    // R5
    lane1_fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_w[0].wr && dec_w[0].rd != '0 && dec_w[0].rd == dec_w[1].rs2) |-> (opb_w[1] == res_w[0]));
  end

endmodule

// File: tb/q4x_exec_tb.sv
module q4x_exec_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bndl_vld = 1'b0;
  logic         mem_wait = 1'b0;
  logic [31:0]  bndl_pc = '0;
  logic [127:0] bndl_ins = '0;
  logic [2:0]   retire;
  logic [3:0]   wb_en;
  logic [19:0]  wb_rd;
  logic [127:0] wb_data;

  always #2 clk = ~clk;

  q4x_exec u_dut (
    .clk(clk), .rst_n(rst_n), .bndl_vld_i(bndl_vld), .mem_wait_i(mem_wait),
    .bndl_pc_i(bndl_pc), .bndl_ins_i(bndl_ins),
    .retire_o(retire), .wb_en_o(wb_en), .wb_rd_o(wb_rd), .wb_data_o(wb_data)
  );

  typedef struct {
    int          rq;
    int          ret;
    logic [3:0]  en;
    logic [4:0]  rd [4];
    logic [31:0] d  [4];
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] m_rf [32];
  int          nchk = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  function automatic logic [31:0] rr(input logic [6:0] f7, input int rs2, input int rs1,
                                     input logic [2:0] f3, input int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'h33};
  endfunction
  function automatic logic [31:0] ri(input int imm, input int rs1, input logic [2:0] f3, input int rd);
    return {12'(imm), 5'(rs1), f3, 5'(rd), 7'h13};
  endfunction
  function automatic logic [31:0] ru(input logic [19:0] up, input int rd, input logic [6:0] opc);
    return {up, 5'(rd), opc};
  endfunction

  // sequential reference: one instruction against plain operand values
  function automatic void mexec(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] pc, output bit w, output logic [31:0] v);
    logic [31:0] si;
    logic [2:0]  f3;
    si = 32'(signed'(ins[31:20]));
    f3 = ins[14:12];
    w = 1'b1;
    v = '0;
    if (ins[6:0] == 7'h33 && ins[31:25] == 7'h20 && f3 == 3'd0) v = a - b;
    else if (ins[6:0] == 7'h33 || ins[6:0] == 7'h13) begin
      if (ins[6:0] == 7'h13) b = si;
      else if (ins[31:25] != 7'h00) w = 1'b0;
      if      (f3 == 3'd0) v = a + b;
      else if (f3 == 3'd2) v = (signed'(a) < signed'(b)) ? 32'd1 : 32'd0;
      else if (f3 == 3'd3) v = (a < b) ? 32'd1 : 32'd0;
      else if (f3 == 3'd4) v = a ^ b;
      else if (f3 == 3'd6) v = a | b;
      else if (f3 == 3'd7) v = a & b;
      else w = 1'b0;
    end
    else if (ins[6:0] == 7'h37) v = {ins[31:12], 12'h0};
    else if (ins[6:0] == 7'h17) v = pc + {ins[31:12], 12'h0};
    else w = 1'b0;
  endfunction

  task automatic issue(input int rq, input bit vld, input bit pend, input logic [31:0] pc,
                       input logic [31:0] i0, input logic [31:0] i1,
                       input logic [31:0] i2, input logic [31:0] i3);
    exp_t        e;
    logic [31:0] ins [4];
    logic [31:0] tmp [32];
    int          first;
    bit          w;
    logic [31:0] v;
    ins = '{i0, i1, i2, i3};
    @(negedge clk);
    bndl_vld = vld; mem_wait = pend; bndl_pc = pc; bndl_ins = {i3, i2, i1, i0};
    first = 4;
    for (int k = 3; k >= 0; k--)
      if (ins[k][6:0] == 7'h03 || ins[k][6:0] == 7'h23) first = k;
    e.rq  = rq;
    e.ret = (!vld || pend) ? 0 : ((first == 0) ? 1 : first);
    e.en  = '0;
    for (int k = 0; k < 4; k++) begin e.rd[k] = '0; e.d[k] = '0; end
    tmp = m_rf;
    for (int k = 0; k < e.ret; k++) begin
      mexec(ins[k], tmp[ins[k][19:15]], tmp[ins[k][24:20]], pc + 32'(4*k), w, v);
      if (w && ins[k][11:7] != 5'd0) begin
        tmp[ins[k][11:7]] = v;
        e.en[k] = 1'b1; e.rd[k] = ins[k][11:7]; e.d[k] = v;
      end
    end
    m_rf = tmp;
    exp_q.push_back(e);
  endtask

  // monitor: sample 1 ns after the falling edge, 1 ns ahead of the commit edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        nchk++;
        if (int'(retire) != e.ret) begin
          nfail++;
          $display("FAIL R%0d retire count: actual %0d expected %0d", e.rq, retire, e.ret);
        end
        nchk++;
        if (wb_en !== e.en) begin
          nfail++;
          $display("FAIL R%0d write enables: actual %b expected %b", e.rq, wb_en, e.en);
        end
        for (int k = 0; k < 4; k++) begin
          if (e.en[k]) begin
            nchk++;
            if (wb_rd[k*5 +: 5] !== e.rd[k] || wb_data[k*32 +: 32] !== e.d[k]) begin
              nfail++;
              $display("FAIL R%0d lane %0d: actual x%0d=%h expected x%0d=%h", e.rq, k,
                       wb_rd[k*5 +: 5], wb_data[k*32 +: 32], e.rd[k], e.d[k]);
            end
          end
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  localparam logic [31:0] NOPW = 32'h0000_0013;

  initial begin
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: reads right after reset
    issue(12, 1, 0, 32'h0, rr(0,11,10,3'd0,1), rr(0,13,12,3'd0,2), rr(0,15,14,3'd6,3), rr(0,5,0,3'd3,4));
    // R2: immediates with sign extension
    issue(2, 1, 0, 32'h0, ri(5,0,3'd0,1), ri(-3,0,3'd0,2), ri(12'h7FF,0,3'd4,3), ri(-2048,0,3'd6,4));
    // R1: register forms reading the committed file
    issue(1, 1, 0, 32'h10, rr(0,2,1,3'd0,5), rr(7'h20,1,2,3'd0,6), rr(0,4,3,3'd7,7), rr(0,4,3,3'd4,8));
    // R2: ANDI with negative immediate, SUB wrapping
    issue(2, 1, 0, 32'h20, ri(-16,3,3'd7,9), rr(7'h20,3,0,3'd0,10), ri(1,2,3'd4,11), ri(-1,0,3'd6,12));
    // R5: increment chain across all lanes
    issue(5, 1, 0, 32'h30, ri(1,0,3'd0,9), ri(1,9,3'd0,9), ri(1,9,3'd0,9), rr(0,9,9,3'd0,10));
    // R6: two writers of x11, readers between and after
    issue(6, 1, 0, 32'h40, ri(7,0,3'd0,11), ri(9,0,3'd0,11), rr(0,0,11,3'd0,12), ri(3,11,3'd7,11));
    // R6: committed winner read back
    issue(6, 1, 0, 32'h50, rr(0,0,11,3'd0,13), rr(0,11,12,3'd0,14), NOPW, NOPW);
    // R3: signed and unsigned compares
    issue(3, 1, 0, 32'h60, rr(0,1,2,3'd2,13), rr(0,1,2,3'd3,14), ri(-2,2,3'd2,15), ri(-1,1,3'd3,16));
    // R3: equal operands and reversed order
    issue(3, 1, 0, 32'h70, rr(0,1,1,3'd2,13), rr(0,2,1,3'd3,14), ri(5,1,3'd2,15), ri(4,1,3'd3,16));
    // R4: upper immediates, lane address offsets
    issue(4, 1, 0, 32'h100, ru(20'h12345,17,7'h37), ru(20'h00001,18,7'h17), ru(20'h0,19,7'h17), ri(12'h678,17,3'd0,20));
    // R7: x0 targeted by lower lanes stays zero
    issue(7, 1, 0, 32'h110, ri(5,0,3'd0,0), rr(0,0,0,3'd0,21), ri(-1,0,3'd0,22), rr(0,22,22,3'd6,0));
    // R7: x0 read from the file after the attempted write
    issue(7, 1, 0, 32'h120, rr(0,0,0,3'd6,23), ri(0,0,3'd0,24), NOPW, NOPW);
    // R8: shifts and unknown funct7 write nothing but retire
    issue(8, 1, 0, 32'h130, ri(2,1,3'd1,23), rr(0,1,2,3'd5,23), rr(7'h01,1,2,3'd0,23), ri(3,0,3'd0,24));
    // R8: unknown opcode
    issue(8, 1, 0, 32'h140, 32'h0000_007F | (32'd25 << 7), ri(4,24,3'd0,25), NOPW, NOPW);
    // R9: load in lane 2 cuts lanes 2 and 3
    issue(9, 1, 0, 32'h150, ri(1,0,3'd0,25), ri(2,25,3'd0,26), {12'h0,5'd0,3'd2,5'd27,7'h03}, ri(9,0,3'd0,28));
    // R9: store in lane 0 retires alone
    issue(9, 1, 0, 32'h160, {7'h0,5'd1,5'd0,3'd2,5'd0,7'h23}, ri(9,0,3'd0,29), NOPW, NOPW);
    // R9: store in lane 1
    issue(9, 1, 0, 32'h170, ri(6,0,3'd0,29), {7'h0,5'd1,5'd0,3'd2,5'd0,7'h23}, ri(9,0,3'd0,30), NOPW);
    // R9: full retire with no memory lane
    issue(9, 1, 0, 32'h180, rr(0,26,25,3'd0,27), NOPW, NOPW, rr(0,29,27,3'd0,28));
    // R10: memory wait blocks everything
    issue(10, 1, 1, 32'h190, ri(5,0,3'd0,30), ri(6,0,3'd0,31), NOPW, NOPW);
    // R11: idle bundle blocks everything
    issue(11, 0, 0, 32'h1A0, ri(7,0,3'd0,30), ri(8,0,3'd0,31), NOPW, NOPW);
    // R10 R11: x30 and x31 untouched
    issue(10, 1, 0, 32'h1B0, rr(0,0,30,3'd0,1), rr(0,0,31,3'd0,2), NOPW, NOPW);
    // R5 R6: collision and forwarding in one bundle ahead of a load
    issue(5, 1, 0, 32'h1C0, ri(10,0,3'd0,3), ri(20,3,3'd0,3), rr(0,3,3,3'd0,4), {12'h0,5'd0,3'd2,5'd5,7'h03});
    issue(6, 1, 0, 32'h1D0, rr(0,0,3,3'd0,6), rr(0,0,4,3'd0,7), NOPW, NOPW);
    @(negedge clk);
    bndl_vld = 1'b0; mem_wait = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule